// File: doc/BRIEF.md
# Frame-Synchronous Serial Audio Sample Port

This block connects on-chip logic to an audio converter over a three-wire serial link: a bit clock, a frame sync and a data line in each direction. The converter drives both the bit clock and the frame sync. Each frame carries one 16-bit signed sample in a single phase. The most significant bit comes first. The first data bit shares its bit period with the frame sync pulse, so there is no delay bit. Received bits are sampled when the bit clock rises. Transmitted bits change when the bit clock falls.

All serial inputs pass through a two-flop synchronizer into the system clock domain, and bit clock edges are detected there. The system clock must run several times faster than the bit clock. Received words come out right-justified, together with a one-cycle valid strobe. That strobe also serves as the receive-ready request for a DMA engine. Transmit words enter a holding register through a ready/valid handshake. When a frame starts, the held word moves to the shifter, and a one-cycle transmit-ready event tells the DMA engine that the holding register is free again. Because this event fires only on that move, the first event after reset needs one word to be written first.

Two one-cycle flags report errors. One marks a received word that was lost because the previous word had not been taken. The other marks a frame that started with no transmit word loaded. A loopback input routes the port's own serial output into its receiver.

Top module: `audio_serial_port`

## Requirements
- R1: During reset and in the first cycle after it, tx_ready_o is 1, and rx_valid_o, tx_event_o, overrun_o, underrun_o and ser_dout_o are all 0.
- R2: On a bit clock rising edge where frame sync is high, the data line carries the MSB. The next 15 rising edges carry the remaining bits, MSB first. The word appears right-justified on rx_data_o, with rx_valid_o high for exactly one system cycle, a few system cycles after the 16th rising edge.
- R3: rx_data_o holds the last completed word until the next word completes.
- R4: If a word completes while the previous word has not been acknowledged by a one-cycle rx_take_i pulse, overrun_o pulses in the same cycle as rx_valid_o. If the previous word was acknowledged, overrun_o stays 0.
- R5: tx_ready_o is 1 exactly when the holding register is empty. A word is accepted in a cycle where tx_valid_i and tx_ready_o are both 1, and tx_ready_o is 0 in the next cycle.
- R6: When frame sync rises, a held word moves to the shifter, and its MSB is on ser_dout_o before the next bit clock rising edge. Each later falling edge presents the next bit. After the 16th bit, ser_dout_o is 0.
- R7: tx_event_o pulses for one cycle when a held word moves to the shifter, and at no other time. In particular, no event occurs after reset until a word has been written.
- R8: If frame sync rises while the holding register is empty, underrun_o pulses for one cycle and the whole frame is sent as zeros.
- R9: While loopback_i is 1, the receiver samples the port's own ser_dout_o and ignores ser_din_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bclk_i | input | 1 | External bit clock |
| ser_fs_i | input | 1 | External frame sync, active high |
| ser_din_i | input | 1 | Serial receive data |
| ser_dout_o | output | 1 | Serial transmit data |
| loopback_i | input | 1 | Routes transmit output into the receiver |
| tx_data_i | input | WORD_W | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register empty |
| tx_event_o | output | 1 | Transmit-ready event, one cycle |
| underrun_o | output | 1 | Frame started with nothing to send |
| rx_data_o | output | WORD_W | Last received word, right-justified |
| rx_valid_o | output | 1 | Receive-ready strobe, one cycle |
| rx_take_i | input | 1 | Acknowledges the current received word |
| overrun_o | output | 1 | Received word arrived before the previous was taken |

## Verification
If the receive bit counter is off, the error shows within one frame: rx_data_o comes out shifted, and rx_valid_o lands on the wrong bit edge. If the transmit remaining-bit count or the holding flag goes wrong, the next frame sends bits that do not match the written word, tx_ready_o stays in the wrong level, or tx_event_o and underrun_o fire in the wrong frame. A stale pending-word flag shows up as a spurious or missing overrun pulse on the next received word. The bench compares every transmitted bit at the converter's sampling edge and every received word against a bench model that mixes random traffic with the acknowledge pattern and loopback mode.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef struct packed {
    logic bclk;
    logic fs;
    logic din;
  } asp_line_t;

  localparam int unsigned LINE_W = $bits(asp_line_t);
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              fs_i,
  input  logic              bit_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nx;
  logic [CNT_W-1:0]  count_q;
  logic              busy_q;
  logic              pend_q;
  logic              done;

  assign shift_nx = {shift_q[WORD_W-2:0], bit_i};
  assign done     = tick_i && !fs_i && busy_q && (count_q == CNT_W'(WORD_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      count_q   <= '0;
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      if (tick_i) begin
        if (fs_i) begin
          shift_q <= shift_nx;
          count_q <= CNT_W'(1);
          busy_q  <= 1'b1;
        end else if (busy_q) begin
          shift_q <= shift_nx;
          count_q <= count_q + CNT_W'(1);
          if (count_q == CNT_W'(WORD_W-1)) busy_q <= 1'b0;
        end
      end
      if (done) begin
        data_o    <= shift_nx;
        valid_o   <= 1'b1;
        overrun_o <= pend_q && !take_i;
        pend_q    <= 1'b1;
      end else if (take_i) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              event_o,
  output logic              underrun_o,
  output logic              dout_o
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      shift_q    <= '0;
      left_q     <= '0;
      ready_o    <= 1'b1;
      event_o    <= 1'b0;
      underrun_o <= 1'b0;
      dout_o     <= 1'b0;
    end else begin
      event_o    <= 1'b0;
      underrun_o <= 1'b0;
      if (load_i) begin
        if (!ready_o) begin
          dout_o  <= hold_q[WORD_W-1];
          shift_q <= {hold_q[WORD_W-2:0], 1'b0};
          left_q  <= CNT_W'(WORD_W-1);
          ready_o <= 1'b1;
          event_o <= 1'b1;
        end else begin
          dout_o     <= 1'b0;
          shift_q    <= '0;
          left_q     <= '0;
          underrun_o <= 1'b1;
        end
      end else if (shift_i) begin
        if (left_q != '0) begin
          dout_o  <= shift_q[WORD_W-1];
          shift_q <= {shift_q[WORD_W-2:0], 1'b0};
          left_q  <= left_q - CNT_W'(1);
        end else begin
          dout_o <= 1'b0;
        end
      end
      if (valid_i && ready_o) begin
        hold_q  <= data_i;
        ready_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bclk_i,
  input  logic              ser_fs_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  input  logic              loopback_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_event_o,
  output logic              underrun_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_take_i,
  output logic              overrun_o
);
  import asp_pkg::*;

  asp_line_t line_raw, line_s;
  logic      bclk_d, fs_d;
  logic      bclk_rise, bclk_fall, fs_rise;
  logic      rx_bit;

  assign line_raw = '{bclk: ser_bclk_i, fs: ser_fs_i, din: ser_din_i};

  asp_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (line_raw),
    .sync_o  (line_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      fs_d   <= 1'b0;
    end else begin
      bclk_d <= line_s.bclk;
      fs_d   <= line_s.fs;
    end
  end

  assign bclk_rise = line_s.bclk && !bclk_d;
  assign bclk_fall = !line_s.bclk && bclk_d;
  assign fs_rise   = line_s.fs && !fs_d;
  assign rx_bit    = loopback_i ? ser_dout_o : line_s.din;

  asp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load_i     (fs_rise),
    .shift_i    (bclk_fall),
    .data_i     (tx_data_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .event_o    (tx_event_o),
    .underrun_o (underrun_o),
    .dout_o     (ser_dout_o)
  );

  asp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (bclk_rise),
    .fs_i      (line_s.fs),
    .bit_i     (rx_bit),
    .take_i    (rx_take_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic clk,
  input logic rst,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_event_o,
  input logic underrun_o,
  input logic rx_valid_o,
  input logic overrun_o,
  input logic ser_dout_o
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_ready_o && !rx_valid_o && !tx_event_o && !ser_dout_o));

  assert_rx_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  assert_overrun_with_word_R4: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> rx_valid_o);

  assert_accept_drops_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  assert_event_frees_holding_R7: assert property (@(posedge clk) disable iff (rst)
    tx_event_o |-> (tx_ready_o && !$past(tx_ready_o)));

  assert_event_single_R7: assert property (@(posedge clk) disable iff (rst)
    tx_event_o |=> !tx_event_o);

  assert_underrun_not_event_R8: assert property (@(posedge clk) disable iff (rst)
    !(underrun_o && tx_event_o));
endmodule

bind audio_serial_port asp_checker u_asp_checker (
  .clk        (clk),
  .rst        (rst),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .tx_event_o (tx_event_o),
  .underrun_o (underrun_o),
  .rx_valid_o (rx_valid_o),
  .overrun_o  (overrun_o),
  .ser_dout_o (ser_dout_o)
);

// File: tb/test_audio_serial_port.sv
module test_audio_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int HALF_BIT   = 8;
  localparam int FRAME_BITS = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b0, fs = 1'b0, din = 1'b0, lb = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0, take = 1'b0;
  logic         dout, tx_ready, tx_event, underrun, rx_valid, overrun;
  logic [W-1:0] rx_data;

  int n_checks = 0, n_fail = 0;
  int cnt_rx = 0, cnt_ev = 0, cnt_ovr = 0, cnt_und = 0;
  logic [W-1:0] last_rx = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_port #(.WORD_W(W)) i_audio_serial_port (
    .clk(clk), .rst(rst), .ser_bclk_i(bclk), .ser_fs_i(fs), .ser_din_i(din),
    .ser_dout_o(dout), .loopback_i(lb), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_event_o(tx_event), .underrun_o(underrun),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_take_i(take), .overrun_o(overrun)
  );

  always @(negedge clk) if (!rst) begin
    if (rx_valid) begin cnt_rx++; last_rx = rx_data; end
    if (tx_event) cnt_ev++;
    if (overrun)  cnt_ovr++;
    if (underrun) cnt_und++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_rx(input logic loop, input logic [W-1:0] sent,
                                         input logic [W-1:0] line_word);
    return loop ? sent : line_word;
  endfunction

  // Converter model: frame sync and data change with the falling bit clock,
  // the port output is sampled just before the rising bit clock.
  task automatic frame(input logic [W-1:0] rxw, output logic [W-1:0] seen,
                       output logic tail_zero);
    seen = '0;
    tail_zero = 1'b1;
    for (int b = 0; b < FRAME_BITS; b++) begin
      @(negedge clk);
      bclk = 1'b0;
      fs   = (b == 0);
      din  = (b < W) ? rxw[W-1-b] : 1'($urandom);
      repeat (HALF_BIT-1) @(negedge clk);
      @(negedge clk);
      if (b < W) seen[W-1-b] = dout;
      else if (dout !== 1'b0) tail_zero = 1'b0;
      bclk = 1'b1;
      repeat (HALF_BIT-1) @(negedge clk);
    end
  endtask

  task automatic write_word(input logic [W-1:0] w);
    @(negedge clk);
    chk("R5 ready before write", tx_ready, 1);
    tx_data = w; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R5 ready low after accept", tx_ready, 0);
  endtask

  task automatic take_word();
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seen, rxw, txw, exp_tx;
    logic tz;
    int ev0, ovr0, und0, rx0;
    bit pend;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 dout", dout, 0);
    chk("R1 flags", {overrun, underrun, tx_event}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {tx_ready, rx_valid, dout}, 3'b100);

    // R8 / R7: frame with nothing loaded
    frame(16'hA5C3, seen, tz);
    chk("R8 zeros sent", seen, 0);
    chk("R8 underrun count", cnt_und, 1);
    chk("R7 no event before first write", cnt_ev, 0);
    chk("R2 first word", last_rx, 16'hA5C3);
    chk("R2 one strobe", cnt_rx, 1);
    take_word();

    // R5/R6/R7: directed corner words
    write_word(16'h8001);
    chk("R7 no event on write alone", cnt_ev, 0);
    frame(16'h7FFE, seen, tz);
    chk("R6 bits MSB first", seen, 16'h8001);
    chk("R6 tail zero", tz, 1);
    chk("R7 event on transfer", cnt_ev, 1);
    chk("R5 ready after transfer", tx_ready, 1);
    chk("R2 rx word", last_rx, 16'h7FFE);
    take_word();

    // R4: two words without acknowledge
    ovr0 = cnt_ovr;
    frame(16'h1234, seen, tz);
    chk("R4 no overrun after take", cnt_ovr, ovr0);
    frame(16'hFFFF, seen, tz);
    chk("R4 overrun when not taken", cnt_ovr, ovr0 + 1);
    chk("R3 data is newest", last_rx, 16'hFFFF);
    take_word();
    @(negedge clk);
    chk("R3 data held", rx_data, 16'hFFFF);

    // R9: loopback ignores line data
    lb = 1'b1;
    write_word(16'h5A3C);
    frame(16'h0F0F, seen, tz);
    chk("R9 loopback word", last_rx, 16'h5A3C);
    take_word();
    lb = 1'b0;

    // Random mix checked against the bench model
    pend = 1'b0;
    for (int i = 0; i < 28; i++) begin
      bit wr, tk;
      logic lp;
      wr  = ($urandom % 4) != 0;
      tk  = ($urandom % 4) != 0;
      lp  = 1'($urandom);
      rxw = W'($urandom);
      txw = W'($urandom);
      lb  = lp;
      ev0 = cnt_ev; ovr0 = cnt_ovr; und0 = cnt_und; rx0 = cnt_rx;
      if (wr) write_word(txw);
      exp_tx = wr ? txw : '0;
      frame(rxw, seen, tz);
      chk("R6 random tx bits", seen, exp_tx);
      chk("R6 random tail", tz, 1);
      chk("R7 random event", cnt_ev - ev0, wr ? 1 : 0);
      chk("R8 random underrun", cnt_und - und0, wr ? 0 : 1);
      chk("R2 random strobe", cnt_rx - rx0, 1);
      chk(lp ? "R9 random loopback" : "R2 random rx", last_rx, exp_rx(lp, exp_tx, rxw));
      chk("R4 random overrun", cnt_ovr - ovr0, pend ? 1 : 0);
      if (tk) take_word();
      pend = !tk;
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule